// File: doc/BRIEF.md
# Serial Master Interrupt Cause Register

This block collects the interrupt causes of a combined I2C and SPI serial master. Single-cycle event pulses from the I2C engine set sticky cause bits: NACK received, ACK received and STOP sent. Two causes are derived inside the block from raw I2C information. Arbitration loss is a mismatch between the driven and the sampled data-line value at a sample strobe. A bus error is a START or STOP condition that the master did not expect. The SPI transfer-done cause is built from three status levels: transmit FIFO empty, transmit shifter empty and slave select released. It fires on the cycle in which all three first hold together.

Software reads the causes through a small word-addressed register port and clears a cause by writing 1 to its bit. A 32-bit mask register and a read-only masked view (cause AND mask) drive one interrupt line. While the peripheral is disabled, every cause is held at zero. A one-cycle wake pulse, seen on return from the deep low-power mode, also wipes every cause.

Top module: `smi_cause_reg`

## Requirements
- R1: After reset the cause word, the mask word and the masked view all read 0, and `irq` is 0.
- R2: The cause word has six live bits: 0 arbitration lost, 1 NACK, 2 ACK, 4 STOP, 8 bus error, 9 SPI done. Every other bit reads 0, and writing 1 to those bits changes nothing.
- R3: A write to word address 0 clears each cause bit whose data bit is 1 and leaves each cause bit whose data bit is 0 unchanged. The result is visible in the cycle after the write edge.
- R4: A one-cycle high on `nack_evt`, `ack_evt` or `stop_evt` sets cause bit 1, 2 or 4. The bit reads 1 in the cycle after the edge that samples the pulse and stays 1 until it is cleared.
- R5: Cause bit 0 sets only in a cycle where `sda_chk` is 1 and `sda_drv` differs from `sda_smp`. A mismatch while `sda_chk` is 0 sets nothing.
- R6: Cause bit 8 sets when `start_det` or `stop_det` is 1 while `cond_exp` is 0. A START or STOP seen while `cond_exp` is 1 sets nothing.
- R7: Cause bit 9 sets once, on the first cycle in which `txf_empty`, `shf_empty` and `ss_idle` are all 1. It does not set again while the three stay high. It can set again only after at least one of them has dropped and all three return. Two of the three alone never set it.
- R8: When a hardware set and a software write-one-clear hit the same bit in the same cycle, the bit ends up 1.
- R9: While `enable` is 0, every cause bit is 0 from the next cycle on, and events during that time set nothing. The mask register is unaffected.
- R10: A cycle with `wake` high forces every cause bit to 0, including a bit whose event arrives in the same cycle.
- R11: Word address 1 is a 32-bit read/write mask register. Word address 2 reads cause AND mask and ignores writes. Word address 3 reads 0.
- R12: `irq` is 1 exactly when cause AND mask is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Peripheral enable; 0 holds all causes clear |
| wake | input | 1 | One-cycle pulse on return from deep low-power mode |
| nack_evt | input | 1 | I2C NACK received pulse |
| ack_evt | input | 1 | I2C ACK received pulse |
| stop_evt | input | 1 | I2C STOP transmitted pulse |
| sda_chk | input | 1 | Data-line sample strobe for arbitration compare |
| sda_drv | input | 1 | Data-line value driven by the master |
| sda_smp | input | 1 | Data-line value sampled from the bus |
| start_det | input | 1 | START condition detected |
| stop_det | input | 1 | STOP condition detected |
| cond_exp | input | 1 | Master expects a START/STOP now |
| txf_empty | input | 1 | SPI transmit FIFO empty |
| shf_empty | input | 1 | SPI transmit shifter empty |
| ss_idle | input | 1 | SPI slave select deasserted |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word address: 0 cause, 1 mask, 2 masked view, 3 none |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq | output | 1 | Interrupt line |

## Verification
The single I2C pulses are applied one at a time and together, so that a wrong bit position can be told apart from a missing set. The derived causes are tried both with a qualifier held off and with it on: a data-line mismatch without a strobe, a START while one is expected, and only two of the three SPI conditions. This separates the qualification from raw pass-through. The SPI condition is held high for several cycles and cleared in the middle, which exposes a level detector in place of an edge detector. Directed collisions of a set with a clear, with disable and with a wake pulse fix the priority order. A random mix of events, writes, disables and wake pulses is then checked on every cycle against a model of the requirements.

// File: rtl/smi_pkg.sv
package smi_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 2;

  localparam int unsigned B_ARB  = 0;
  localparam int unsigned B_NACK = 1;
  localparam int unsigned B_ACK  = 2;
  localparam int unsigned B_STOP = 4;
  localparam int unsigned B_BERR = 8;
  localparam int unsigned B_SPI  = 9;

  localparam logic [DATA_W-1:0] IMPL_MASK =
    (DATA_W'(1) << B_ARB)  | (DATA_W'(1) << B_NACK) |
    (DATA_W'(1) << B_ACK)  | (DATA_W'(1) << B_STOP) |
    (DATA_W'(1) << B_BERR) | (DATA_W'(1) << B_SPI);

  typedef enum logic [ADDR_W-1:0] {
    A_CAUSE  = 2'd0,
    A_MASK   = 2'd1,
    A_MASKED = 2'd2,
    A_NONE   = 2'd3
  } smi_addr_e;

  function automatic logic f_arb_mismatch(logic chk, logic drv, logic smp);
    return chk & (drv ^ smp);
  endfunction

  function automatic logic f_bus_err(logic st, logic sp, logic expct);
    return (st | sp) & ~expct;
  endfunction

  function automatic logic f_spi_ready(logic fifo_e, logic shf_e, logic ss_off);
    return fifo_e & shf_e & ss_off;
  endfunction

  function automatic logic f_bit_next(logic cur, logic set, logic clr, logic wipe);
    return wipe ? 1'b0 : ((cur & ~clr) | set);
  endfunction
endpackage

// File: rtl/smi_i2c_detect.sv
module smi_i2c_detect
  import smi_pkg::*;
(
  input  logic sda_chk,
  input  logic sda_drv,
  input  logic sda_smp,
  input  logic start_det,
  input  logic stop_det,
  input  logic cond_exp,
  output logic arb_evt,
  output logic berr_evt
);
  assign arb_evt  = f_arb_mismatch(sda_chk, sda_drv, sda_smp);
  assign berr_evt = f_bus_err(start_det, stop_det, cond_exp);
endmodule

// File: rtl/smi_spi_done.sv
module smi_spi_done
  import smi_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic txf_empty,
  input  logic shf_empty,
  input  logic ss_idle,
  output logic done_evt
);
  logic ready_now;
  logic ready_q;

  assign ready_now = f_spi_ready(txf_empty, shf_empty, ss_idle);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= ready_now;
  end

  assign done_evt = ready_now & ~ready_q;
endmodule

// File: rtl/smi_cause_bank.sv
module smi_cause_bank
  import smi_pkg::*;
#(
  parameter int unsigned WIDTH = DATA_W,
  parameter logic [WIDTH-1:0] LIVE = IMPL_MASK
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wipe,
  input  logic [WIDTH-1:0] set_vec,
  input  logic [WIDTH-1:0] clr_vec,
  output logic [WIDTH-1:0] cause_q
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (LIVE[i]) begin : g_live
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cause_q[i] <= 1'b0;
        else        cause_q[i] <= f_bit_next(cause_q[i], set_vec[i], clr_vec[i], wipe);
      end
    end else begin : g_dead
      logic unused_in;
      assign unused_in  = set_vec[i] ^ clr_vec[i];
      assign cause_q[i] = unused_in & 1'b0;
    end
  end
endmodule

// File: rtl/smi_cause_reg.sv
module smi_cause_reg
  import smi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              wake,
  input  logic              nack_evt,
  input  logic              ack_evt,
  input  logic              stop_evt,
  input  logic              sda_chk,
  input  logic              sda_drv,
  input  logic              sda_smp,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              cond_exp,
  input  logic              txf_empty,
  input  logic              shf_empty,
  input  logic              ss_idle,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  logic              arb_evt;
  logic              berr_evt;
  logic              spi_evt;
  logic              wipe;
  logic [DATA_W-1:0] set_vec;
  logic [DATA_W-1:0] clr_vec;
  logic [DATA_W-1:0] cause_q;
  logic [DATA_W-1:0] mask_q;
  logic [DATA_W-1:0] masked;

  smi_i2c_detect u_i2c (
    .sda_chk  (sda_chk),
    .sda_drv  (sda_drv),
    .sda_smp  (sda_smp),
    .start_det(start_det),
    .stop_det (stop_det),
    .cond_exp (cond_exp),
    .arb_evt  (arb_evt),
    .berr_evt (berr_evt)
  );

  smi_spi_done u_spi (
    .clk      (clk),
    .rst_n    (rst_n),
    .txf_empty(txf_empty),
    .shf_empty(shf_empty),
    .ss_idle  (ss_idle),
    .done_evt (spi_evt)
  );

  always_comb begin
    set_vec         = '0;
    set_vec[B_ARB]  = arb_evt;
    set_vec[B_NACK] = nack_evt;
    set_vec[B_ACK]  = ack_evt;
    set_vec[B_STOP] = stop_evt;
    set_vec[B_BERR] = berr_evt;
    set_vec[B_SPI]  = spi_evt;
  end

  assign clr_vec = (reg_wr && reg_addr == A_CAUSE) ? reg_wdata : '0;
  assign wipe    = ~enable | wake;

  smi_cause_bank #(.WIDTH(DATA_W), .LIVE(IMPL_MASK)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .wipe   (wipe),
    .set_vec(set_vec),
    .clr_vec(clr_vec),
    .cause_q(cause_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          mask_q <= '0;
    else if (reg_wr && reg_addr == A_MASK) mask_q <= reg_wdata;
  end

  assign masked = cause_q & mask_q;
  assign irq    = |masked;

  always_comb begin
    unique case (reg_addr)
      A_CAUSE:  reg_rdata = cause_q;
      A_MASK:   reg_rdata = mask_q;
      A_MASKED: reg_rdata = masked;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/smi_cause_reg_chk.sv
module smi_cause_reg_chk
  import smi_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              wake,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [DATA_W-1:0] set_vec,
  input logic [DATA_W-1:0] cause_q,
  input logic [DATA_W-1:0] mask_q,
  input logic              spi_evt,
  input logic              irq
);
  assert_dead_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_CAUSE) |-> ((reg_rdata & ~IMPL_MASK) == '0));

  assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !wake && reg_wr && reg_addr == A_CAUSE && set_vec == '0)
    |=> (cause_q == ($past(cause_q) & ~$past(reg_wdata))));

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !wake && set_vec != '0)
    |=> ((cause_q & $past(set_vec)) == $past(set_vec)));

  assert_spi_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
    spi_evt |=> !spi_evt);

  assert_disable_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (cause_q == '0));

  assert_wake_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> (cause_q == '0));

  assert_irq_R12: assert property (@(posedge clk) disable iff (!rst_n)
    irq == ((cause_q & mask_q) != '0));
endmodule

bind smi_cause_reg smi_cause_reg_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .enable   (enable),
  .wake     (wake),
  .reg_wr   (reg_wr),
  .reg_addr (reg_addr),
  .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata),
  .set_vec  (set_vec),
  .cause_q  (cause_q),
  .mask_q   (mask_q),
  .spi_evt  (spi_evt),
  .irq      (irq)
);

// File: tb/tb_smi_cause_reg.sv
`timescale 1ns/1ps
module tb_smi_cause_reg;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable, wake, nack_evt, ack_evt, stop_evt;
  logic sda_chk, sda_drv, sda_smp, start_det, stop_det, cond_exp;
  logic txf_empty, shf_empty, ss_idle, reg_wr;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] m_cause = 0, m_mask = 0;
  logic m_prev = 0;
  localparam logic [31:0] LIVE = 32'h0000_0317;

  always #10 clk = ~clk;

  smi_cause_reg dut (.*);

  function automatic logic [31:0] exp_read(logic [1:0] a);
    case (a)
      2'd0: return m_cause;
      2'd1: return m_mask;
      2'd2: return m_cause & m_mask;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] model_set();
    logic [31:0] s = 0;
    logic rdy = txf_empty && shf_empty && ss_idle;
    s[0] = sda_chk && (sda_drv != sda_smp);
    s[1] = nack_evt;
    s[2] = ack_evt;
    s[4] = stop_evt;
    s[8] = (start_det || stop_det) && !cond_exp;
    s[9] = rdy && !m_prev;
    return s;
  endfunction

  task automatic idle();
    wake = 0; nack_evt = 0; ack_evt = 0; stop_evt = 0;
    sda_chk = 0; sda_drv = 0; sda_smp = 0;
    start_det = 0; stop_det = 0; cond_exp = 0;
    reg_wr = 0; reg_addr = 0; reg_wdata = 0;
  endtask

  task automatic tick();
    logic [31:0] s, c;
    @(posedge clk);
    s = model_set();
    c = (reg_wr && reg_addr == 2'd0) ? reg_wdata : 32'h0;
    if (!enable || wake) m_cause = 0;
    else m_cause = ((m_cause & ~c) | s) & LIVE;
    if (reg_wr && reg_addr == 2'd1) m_mask = reg_wdata;
    m_prev = txf_empty && shf_empty && ss_idle;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic rd(logic [1:0] a, string tag);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp_read(a));
    chk("R12", {31'b0, irq}, {31'b0, (m_cause & m_mask) != 0});
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    idle(); enable = 1; txf_empty = 0; shf_empty = 0; ss_idle = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1 reset state
    rd(0, "R1"); rd(1, "R1"); rd(2, "R1");
    chk("R1", {31'b0, irq}, 32'h0);

    // R4 single event pulses
    nack_evt = 1; tick(); idle(); rd(0, "R4");
    chk("R4", reg_rdata, 32'h2);
    ack_evt = 1; stop_evt = 1; tick(); idle(); rd(0, "R4");
    chk("R4", reg_rdata, 32'h16);

    // R5 arbitration compare
    sda_drv = 1; sda_smp = 0; sda_chk = 0; tick(); idle(); rd(0, "R5");
    chk("R5", reg_rdata & 32'h1, 32'h0);
    sda_drv = 1; sda_smp = 1; sda_chk = 1; tick(); idle(); rd(0, "R5");
    chk("R5", reg_rdata & 32'h1, 32'h0);
    sda_drv = 0; sda_smp = 1; sda_chk = 1; tick(); idle(); rd(0, "R5");
    chk("R5", reg_rdata & 32'h1, 32'h1);

    // R6 bus error
    start_det = 1; cond_exp = 1; tick(); idle(); rd(0, "R6");
    chk("R6", reg_rdata & 32'h100, 32'h0);
    stop_det = 1; cond_exp = 0; tick(); idle(); rd(0, "R6");
    chk("R6", reg_rdata & 32'h100, 32'h100);

    // R3 write-one-clear and write-zero
    wr(0, 32'h1); tick(); rd(0, "R3");
    chk("R3", reg_rdata, 32'h116);
    wr(0, 32'h0); tick(); rd(0, "R3");
    chk("R3", reg_rdata, 32'h116);
    // R2 dead bits ignore writes and read 0
    wr(0, ~LIVE); tick(); rd(0, "R2");
    chk("R2", reg_rdata, 32'h116);
    wr(0, 32'hFFFF_FFFF); tick(); rd(0, "R3");
    chk("R3", reg_rdata, 32'h0);

    // R7 SPI done qualification
    txf_empty = 1; shf_empty = 1; ss_idle = 0; tick(); rd(0, "R7");
    chk("R7", reg_rdata, 32'h0);
    ss_idle = 1; tick(); rd(0, "R7");
    chk("R7", reg_rdata, 32'h200);
    wr(0, 32'h200); tick(); rd(0, "R7");
    tick(); tick(); rd(0, "R7");
    chk("R7", reg_rdata, 32'h0);
    shf_empty = 0; tick(); shf_empty = 1; tick(); rd(0, "R7");
    chk("R7", reg_rdata, 32'h200);
    txf_empty = 0; wr(0, 32'h200); tick(); rd(0, "R7");

    // R8 set beats clear
    nack_evt = 1; wr(0, 32'h2); tick(); idle(); rd(0, "R8");
    chk("R8", reg_rdata & 32'h2, 32'h2);

    // R11 mask, masked view, unused address; R12 irq
    wr(1, 32'h8000_0204); tick(); rd(1, "R11"); rd(2, "R11");
    chk("R12", {31'b0, irq}, 32'h0);
    ack_evt = 1; tick(); idle(); rd(2, "R11");
    chk("R12", {31'b0, irq}, 32'h1);
    wr(2, 32'h0); tick(); rd(2, "R11");
    wr(3, 32'hFFFF_FFFF); tick(); rd(3, "R11"); rd(1, "R11");

    // R9 disable wipes and blocks sets, mask kept
    enable = 0; stop_evt = 1; nack_evt = 1; tick(); idle(); rd(0, "R9");
    chk("R9", reg_rdata, 32'h0);
    stop_det = 1; tick(); idle(); rd(0, "R9"); rd(1, "R9");
    enable = 1;

    // R10 wake wipes, beating a same-cycle event
    nack_evt = 1; ack_evt = 1; tick(); idle(); rd(0, "R10");
    wake = 1; stop_evt = 1; tick(); idle(); rd(0, "R10");
    chk("R10", reg_rdata, 32'h0);

    // random mix
    for (int i = 0; i < 600; i++) begin
      enable    = ($urandom % 16) != 0;
      wake      = ($urandom % 32) == 0;
      nack_evt  = ($urandom % 4) == 0;
      ack_evt   = ($urandom % 4) == 0;
      stop_evt  = ($urandom % 6) == 0;
      sda_chk   = ($urandom % 3) == 0;
      sda_drv   = 1'($urandom);
      sda_smp   = 1'($urandom);
      start_det = ($urandom % 6) == 0;
      stop_det  = ($urandom % 6) == 0;
      cond_exp  = 1'($urandom);
      txf_empty = ($urandom % 4) != 0;
      shf_empty = ($urandom % 4) != 0;
      ss_idle   = ($urandom % 4) != 0;
      reg_wr    = ($urandom % 3) == 0;
      reg_addr  = 2'($urandom);
      reg_wdata = $urandom;
      tick();
      begin
        logic [1:0] a = 2'($urandom);
        rd(a, (a == 2'd0) ? "R4" : "R11");
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule